// File: doc/BRIEF.md
# Clock Frequency Window Monitor

This block watches a clock that arrives from outside the master-clock domain and decides whether it runs inside a programmed frequency band. The monitored clock is sampled into the master domain, and its rising edges are divided by a 16-bit prescale value. The block then counts master-clock cycles from one prescaled tick to the next and compares each count with a lower and an upper limit. A count above the upper limit means the input is too slow, or has stopped. A count below the lower limit means it is too fast.

Results go to a six-bit sticky status register. Software clears bits by writing ones, and it can also force bits through a manual-set path. An external loss indication with selectable polarity feeds the same register. Two outputs are derived from the status: a loss output with selectable polarity, and an interrupt gated by a per-bit enable mask. Status bit meanings: bit 0 too slow, bit 1 too fast, bit 2 external loss, bit 3 any loss event, bits 4 and 5 settable only by software.

Top module: `clk_window_mon`

## Requirements
- R1: One measured interval spans `div_cfg` rising edges of the monitored clock, or every rising edge when `div_cfg` is 0 or 1. With the same input, a larger divisor gives a proportionally longer interval.
- R2: Status bit 0 sets as soon as the running cycle count exceeds `max_cfg`. It does not wait for the next tick, so a stopped input clock is flagged and stays flagged while it remains stopped.
- R3: Status bit 1 sets when a completed interval is shorter than `min_cfg` master-clock cycles.
- R4: The interval counter saturates at 65535 and never wraps. A long-dead clock therefore keeps bit 0 asserting after a clear.
- R5: After reset, and after any change to `div_cfg`, `min_cfg` or `max_cfg`, the prescaler and the counter restart. The first completed interval after the restart is not compared against `min_cfg`.
- R6: Status bit 2 sets while `ext_loss_in` is active. It is active when high if `ext_loss_pol` is 1, and active when low if `ext_loss_pol` is 0.
- R7: Status bit 3 sets together with any hardware event on bits 0, 1 or 2. A manual set does not set it.
- R8: Status bits are sticky. A bit clears only when `clr_we` writes a 1 to it, and a hardware event in the same cycle wins over the clear.
- R9: A `set_we` cycle forces each status bit whose `set_data` bit is 1, and affects only those bits.
- R10: `irq` is high exactly when some status bit and its `irq_en` bit are both 1.
- R11: `loss_out` is active when any of status bits 0 to 2 is set. It is driven high for active if `loss_pol` is 1, and low for active if `loss_pol` is 0.
- R12: After reset the status is 0, `irq` is 0 and `loss_out` shows the inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_clk | input | 1 | Clock under observation, asynchronous to clk |
| div_cfg | input | 16 | Prescale divisor for the monitored clock |
| min_cfg | input | 16 | Shortest allowed interval in clk cycles |
| max_cfg | input | 16 | Longest allowed interval in clk cycles |
| ext_loss_in | input | 1 | External source-loss indication, asynchronous |
| ext_loss_pol | input | 1 | 1: ext_loss_in active high; 0: active low |
| loss_pol | input | 1 | 1: loss_out active high; 0: active low |
| irq_en | input | 6 | Per-bit interrupt enable |
| clr_we | input | 1 | Write-one-to-clear strobe |
| clr_data | input | 6 | Bits to clear |
| set_we | input | 1 | Manual-set strobe |
| set_data | input | 6 | Bits to force |
| status | output | 6 | Sticky status register |
| irq | output | 1 | Interrupt request |
| loss_out | output | 1 | Loss indication with programmable polarity |

## Verification
The hardest state to reach from the ports is a monitored clock that has been dead long enough to carry the interval counter past its full 16-bit range. Only there does saturation differ from wrap-around. The bench sets `max_cfg` to 60000 and stops the monitored clock. After about 66000 cycles it clears the status, at a point where a wrapped counter would have dropped below the limit, and it expects the too-slow flag to come straight back. The discard of the first interval is reached by changing `min_cfg` while the clock runs, so that the partial interval that follows is shorter than the new limit.

// File: rtl/cwm_pkg.sv
// Package: shared widths and status bit positions for the clock window monitor.
// Assumes: the status layout is fixed at six bits; hardware sources occupy bits 0..3.
package cwm_pkg;
    localparam int ST_W   = 6;
    localparam int B_SLOW = 0;
    localparam int B_FAST = 1;
    localparam int B_EXT  = 2;
    localparam int B_ANY  = 3;
    typedef logic [ST_W-1:0] status_t;
endpackage

// File: rtl/cwm_sync.sv
// Module: multi-flop synchronizer carrying an asynchronous level into clk.
// Assumes: the input changes slower than half the clk rate, so no edges are lost.
module cwm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cwm_prescale.sv
// Module: detects rising edges of the synchronized input and emits one tick
// every div edges (div of 0 or 1 means every edge).
// Assumes: restart puts the edge counter back to zero without losing edge history.
module cwm_prescale #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         lvl,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic         lvl_q;
    logic         rise;
    logic [W-1:0] edges;
    logic [W-1:0] last;

    assign rise = lvl & ~lvl_q;
    assign last = (div <= W'(1)) ? '0 : div - 1'b1;
    assign tick = rise && (edges >= last) && !restart;

    // Remember the previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    // Count rising edges, wrapping at the divisor.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) edges <= '0;
        else if (rise)         edges <= (edges >= last) ? '0 : edges + 1'b1;
    end
endmodule

// File: rtl/cwm_interval.sv
// Module: counts clk cycles between prescaled ticks and judges them against
// the window. Too-slow is a level raised while the running count exceeds max;
// too-fast is a pulse on a tick whose interval is below min.
// Assumes: the first tick after restart only arms the comparison.
module cwm_interval #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         tick,
    input  logic [W-1:0] min_lim,
    input  logic [W-1:0] max_lim,
    output logic         slow_evt,
    output logic         fast_evt
);
    logic [W-1:0] cnt;
    logic         armed;

    // Saturating interval counter; a tick starts a new interval at one.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt <= '0;
        else if (tick)         cnt <= W'(1);
        else if (cnt != '1)    cnt <= cnt + 1'b1;
    end

    // Arm the low-limit comparison once a full interval has begun.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) armed <= 1'b0;
        else if (tick)         armed <= 1'b1;
    end

    assign slow_evt = (cnt > max_lim);
    assign fast_evt = tick && armed && (cnt < min_lim);
endmodule

// File: rtl/cwm_status.sv
// Module: sticky status register with write-one-to-clear and manual set.
// Assumes: hardware and manual sets take priority over a same-cycle clear.
module cwm_status
    import cwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  status_t hw_set,
    input  logic    clr_we,
    input  status_t clr_data,
    input  logic    set_we,
    input  status_t set_data,
    output status_t status
);
    status_t clr_mask;
    status_t man_mask;

    assign clr_mask = clr_we ? clr_data : '0;
    assign man_mask = set_we ? set_data : '0;

    // Update sticky bits: clear first, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_mask) | hw_set | man_mask;
    end
endmodule

// File: rtl/clk_window_mon.sv
// Module: top of the clock frequency window monitor. Synchronizes the
// monitored clock and the external loss input, prescales, measures, and
// folds events into the sticky status with interrupt and loss outputs.
// Assumes: mon_clk is slower than half of clk; configuration is quasi-static.
module clk_window_mon
    import cwm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mon_clk,
    input  logic [CNT_W-1:0] div_cfg,
    input  logic [CNT_W-1:0] min_cfg,
    input  logic [CNT_W-1:0] max_cfg,
    input  logic             ext_loss_in,
    input  logic             ext_loss_pol,
    input  logic             loss_pol,
    input  logic [ST_W-1:0]  irq_en,
    input  logic             clr_we,
    input  logic [ST_W-1:0]  clr_data,
    input  logic             set_we,
    input  logic [ST_W-1:0]  set_data,
    output logic [ST_W-1:0]  status,
    output logic             irq,
    output logic             loss_out
);
    localparam int CFG_W = 3 * CNT_W;

    logic             mon_lvl;
    logic             ext_lvl;
    logic             ext_act;
    logic             restart;
    logic             tick;
    logic             slow_evt;
    logic             fast_evt;
    logic             loss_any;
    logic [CFG_W-1:0] cfg_now;
    logic [CFG_W-1:0] cfg_q;
    status_t          hw_set;

    cwm_sync #(.STAGES(SYNC_STAGES)) u_mon_sync (
        .clk(clk), .rst_n(rst_n), .d(mon_clk), .q(mon_lvl)
    );

    cwm_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_loss_in), .q(ext_lvl)
    );

    assign cfg_now = {div_cfg, min_cfg, max_cfg};
    assign restart = (cfg_now != cfg_q);

    // Track the configuration so any change restarts the measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_now;
    end

    cwm_prescale #(.W(CNT_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(restart),
        .lvl(mon_lvl), .div(div_cfg), .tick(tick)
    );

    cwm_interval #(.W(CNT_W)) u_meas (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
        .min_lim(min_cfg), .max_lim(max_cfg),
        .slow_evt(slow_evt), .fast_evt(fast_evt)
    );

    assign ext_act = ext_loss_pol ? ext_lvl : ~ext_lvl;

    // Map hardware events onto their status bit positions.
    always_comb begin
        hw_set         = '0;
        hw_set[B_SLOW] = slow_evt;
        hw_set[B_FAST] = fast_evt;
        hw_set[B_EXT]  = ext_act;
        hw_set[B_ANY]  = slow_evt | fast_evt | ext_act;
    end

    cwm_status u_stat (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_set),
        .clr_we(clr_we), .clr_data(clr_data),
        .set_we(set_we), .set_data(set_data), .status(status)
    );

    assign loss_any = |status[B_EXT:B_SLOW];
    assign loss_out = loss_pol ? loss_any : ~loss_any;
    assign irq      = |(status & irq_en);
endmodule

// File: rtl/clk_window_mon_chk.sv
// Module: property checker bound to clk_window_mon.
// Assumes: it observes only top-level ports.
module clk_window_mon_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] status,
    input logic       irq,
    input logic       loss_out,
    input logic       loss_pol,
    input logic [5:0] irq_en,
    input logic       clr_we,
    input logic       set_we,
    input logic [5:0] set_data
);
    // R8: without a clear strobe no set bit ever drops.
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_we |=> ((status & $past(status)) == $past(status)));

    // R9: every bit named by a manual set is present the next cycle.
    assert_manual_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((status & $past(set_data)) == $past(set_data)));

    // R7: a hardware too-slow event also records the combined loss bit.
    assert_combined_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[0]) && !$past(set_we)) |-> status[3]);

    // R10: forcing an enabled bit raises the interrupt.
    assert_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && ((set_data & irq_en) != 6'd0)) |=> (!$stable(irq_en) || irq));

    // R11: a new external loss drives the loss output to its active level.
    assert_loss_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> (loss_out == loss_pol));

    // R12: a reset cycle leaves the status empty.
    assert_reset_R12: assert property (@(posedge clk)
        !rst_n |=> (status == 6'd0));
endmodule

bind clk_window_mon clk_window_mon_chk u_chk (
    .clk(clk), .rst_n(rst_n), .status(status), .irq(irq),
    .loss_out(loss_out), .loss_pol(loss_pol), .irq_en(irq_en),
    .clr_we(clr_we), .set_we(set_we), .set_data(set_data)
);

// File: tb/sim_clk_window_mon.sv
`timescale 1ns/1ps
module sim_clk_window_mon;
    typedef struct {
        int         sel;   // 0 status, 1 irq, 2 loss_out
        logic [5:0] exp;
        string      req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mon_clk = 1'b0;
    logic [15:0] div_cfg = 16'd4;
    logic [15:0] min_cfg = 16'd28;
    logic [15:0] max_cfg = 16'd36;
    logic        ext_loss_in = 1'b0;
    logic        ext_loss_pol = 1'b1;
    logic        loss_pol = 1'b1;
    logic [5:0]  irq_en = 6'd0;
    logic        clr_we = 1'b0;
    logic [5:0]  clr_data = 6'd0;
    logic        set_we = 1'b0;
    logic [5:0]  set_data = 6'd0;
    logic [5:0]  status;
    logic        irq;
    logic        loss_out;

    int    checks = 0;
    int    errors = 0;
    int    mon_half = 40;
    bit    mon_run = 1'b1;
    bit    done = 1'b0;
    item_t sb[$];

    clk_window_mon u0 (
        .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk),
        .div_cfg(div_cfg), .min_cfg(min_cfg), .max_cfg(max_cfg),
        .ext_loss_in(ext_loss_in), .ext_loss_pol(ext_loss_pol),
        .loss_pol(loss_pol), .irq_en(irq_en),
        .clr_we(clr_we), .clr_data(clr_data),
        .set_we(set_we), .set_data(set_data),
        .status(status), .irq(irq), .loss_out(loss_out)
    );

    always #5 clk = ~clk;

    always begin
        if (mon_run) begin
            #(mon_half) mon_clk = ~mon_clk;
        end else begin
            #10;
        end
    end

    // Monitor: pop expected items and compare at the falling edge.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [5:0] act;
            it = sb.pop_front();
            case (it.sel)
                0:       act = status;
                1:       act = {5'd0, irq};
                default: act = {5'd0, loss_out};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s sel=%0d actual=%b expected=%b", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic expect_out(input int sel, input logic [5:0] exp, input string req);
        item_t it;
        it.sel = sel; it.exp = exp; it.req = req;
        sb.push_back(it);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_clear(input logic [5:0] d);
        @(negedge clk); clr_we = 1'b1; clr_data = d;
        @(negedge clk); clr_we = 1'b0; clr_data = 6'd0;
    endtask

    task automatic do_set(input logic [5:0] d);
        @(negedge clk); set_we = 1'b1; set_data = d;
        @(negedge clk); set_we = 1'b0; set_data = 6'd0;
    endtask

    initial begin
        #(190000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(1);
        expect_out(0, 6'd0, "R12 status after reset");
        expect_out(1, 6'd0, "R12 irq after reset");
        expect_out(2, 6'd0, "R12 loss_out after reset");

        // In band: div 4, 8-cycle input period -> 32-cycle interval.
        wait_cyc(300);
        expect_out(0, 6'd0, "R1 in-band interval, R5 first interval ignored");

        // Too fast: 4-cycle period -> 16-cycle interval.
        mon_half = 20;
        irq_en = 6'b000010;
        wait_cyc(200);
        expect_out(0, 6'b001010, "R3 too-fast with R7 combined");
        expect_out(2, 6'd1, "R11 loss_out active high");
        expect_out(1, 6'd1, "R10 irq on enabled fast bit");

        mon_half = 40;
        wait_cyc(100);
        do_clear(6'h3f);
        wait_cyc(2);
        expect_out(0, 6'd0, "R8 write-one clear");
        expect_out(1, 6'd0, "R10 irq drops after clear");

        // Config change with running clock: partial interval below new min.
        min_cfg = 16'd31;
        wait_cyc(300);
        expect_out(0, 6'd0, "R5 interval after config change ignored");

        // Larger divisor doubles the interval to 64 > 36.
        div_cfg = 16'd8;
        wait_cyc(400);
        expect_out(0, 6'b001001, "R1 divisor 8 gives too-slow, R2");
        div_cfg = 16'd4;
        wait_cyc(100);
        do_clear(6'h3f);
        wait_cyc(2);
        expect_out(0, 6'd0, "R8 clear after divisor restored");

        // External loss, active-low polarity with input low.
        ext_loss_pol = 1'b0;
        wait_cyc(10);
        expect_out(0, 6'b001100, "R6 ext loss active low, R7");
        loss_pol = 1'b0;
        wait_cyc(1);
        expect_out(2, 6'd0, "R11 loss_out active low while loss");
        ext_loss_pol = 1'b1;
        wait_cyc(5);
        do_clear(6'h3f);
        wait_cyc(2);
        expect_out(0, 6'd0, "R6 ext loss inactive after polarity flip");
        expect_out(2, 6'd1, "R11 loss_out idle level with low polarity");
        loss_pol = 1'b1;

        ext_loss_in = 1'b1;
        wait_cyc(10);
        expect_out(0, 6'b001100, "R6 ext loss active high");
        ext_loss_in = 1'b0;
        wait_cyc(5);
        do_clear(6'h3f);
        wait_cyc(2);
        expect_out(0, 6'd0, "R8 clear after ext loss");

        // Manual set of the software-only bits.
        irq_en = 6'b100000;
        do_set(6'b110000);
        wait_cyc(1);
        expect_out(0, 6'b110000, "R9 manual set bits 4 and 5");
        expect_out(2, 6'd0, "R11 loss_out unaffected by bits 4-5");
        expect_out(1, 6'd1, "R10 irq from enabled bit 5");
        irq_en = 6'b000001;
        wait_cyc(1);
        expect_out(1, 6'd0, "R10 irq masked");
        do_clear(6'h3f);
        do_set(6'b000001);
        wait_cyc(1);
        expect_out(0, 6'b000001, "R9 manual bit0 only, R7 no combined bit");
        expect_out(2, 6'd1, "R11 loss_out from manual bit0");
        do_clear(6'h3f);
        wait_cyc(2);
        expect_out(0, 6'd0, "R8 clear manual bit");

        // Dead clock with a high max: detection and saturation.
        max_cfg = 16'd60000;
        mon_run = 1'b0;
        wait_cyc(60100);
        expect_out(0, 6'b001001, "R2 stopped clock flagged too slow");
        wait_cyc(6000);
        do_clear(6'h3f);
        wait_cyc(10);
        expect_out(0, 6'b001001, "R4 counter saturates, flag returns");

        done = 1'b1;
        wait_cyc(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule